// File: doc/BRIEF.md
# Compare-Triggered Staged Pulse Port

This block drives an 8-bit parallel pulse port whose pins change only when a timer period elapses. An internal up-counter runs from zero to a programmed period value and then wraps to zero. Each wrap is a compare match. On a compare match the pattern that software left in a staging register is copied into the output latch. At the same time a sticky event flag is set, which can raise an interrupt. The interrupt handler then loads the next pattern and clears the flag. Software that refills the staging register after every match in this way gets a cyclic multi-phase waveform, such as a five-phase stepper drive, with no timing jitter from the handler.

The port is split into groups of four bits. Each group has its own trigger selector. It can follow the internal compare match or one of several external compare-match strobes, and only the selected source moves that group's bits from staging to latch. A per-bit enable mask gates the latch onto the pins.

The timer has two named states. `TMR_IDLE` holds the counter at zero, and `TMR_IDLE -> TMR_RUN` is taken on the first clock edge that sees the run bit at 1. `TMR_RUN` counts, and `TMR_RUN -> TMR_IDLE` is taken on the first clock edge that sees the run bit at 0. That same edge clears the counter.

Top module: `cmp_pulse_port`

## Requirements
- R1: After reset, `pulse_out` is 0x00, `irq` is 0, and the COUNT, LATCH, STATUS and CTRL registers all read 0.
- R2: The run bit is written on an edge. The timer enters `TMR_RUN` on the next edge and counts up by one per cycle from 0. When the count equals the PERIOD value N, the next edge is a compare match and loads 0. Transfers therefore occur every N+1 cycles, and every cycle when N=0. The first match comes N+2 edges after the run write.
- R3: On a compare match selected by a group, that group's bits of the staging register (NEXT) are copied into the output latch on the same edge. The output latch holds its value between selected matches.
- R4: `pulse_out` equals the output latch AND the OUTEN mask, so disabled bits drive 0. The LATCH register still reads the full latch content.
- R5: Every internal compare match sets STATUS bit 0. `irq` is high exactly when STATUS bit 0 and CTRL bit 1 (interrupt enable) are both 1.
- R6: Writing STATUS with bit 0 = 1 clears the flag. If a compare match occurs on the same edge, the flag stays set.
- R7: TRIG holds one 2-bit selector per group, at bits [2g+1:2g] for the group of port bits [4g+3:4g]. Value 0 selects the internal match, and value k selects `ext_match[k-1]`. A strobe on an unselected source leaves that group unchanged.
- R8: A NEXT write on the same edge as a match does not reach the latch on that edge. The latch takes the pre-write staging value, and the new value follows at the next match.
- R9: With CTRL bit 0 (run) at 0, the counter reads 0, no internal matches occur, and writes to NEXT do not change the port.
- R10: With OUTEN = 0xF8, both groups on the internal match, and NEXT refilled after each match with 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 and then repeating, the port steps through those values in order. Each step has one or two bits high, and the port lags the staging register by one period.
- R11: The register map uses `bus_addr` as follows: 0 = CTRL ({irq_en, run} in bits [1:0]), 1 = PERIOD, 2 = NEXT, 3 = OUTEN, 4 = TRIG, 5 = STATUS (flag in bit 0, write 1 to clear), 6 = LATCH (read only), 7 = COUNT (read only). Writes take effect on the edge where `bus_wr` is 1, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| ext_match | input | 3 | External compare-match strobes, one cycle each |
| irq | output | 1 | Interrupt request: flag AND enable |
| pulse_out | output | 8 | Masked output latch |

## Verification
The assertions assume the following about the inputs:
- `rst_n` is asserted long enough for every register to settle at its reset value.
- `bus_addr` and `bus_wdata` are stable across the edge on which `bus_wr` is high.
- `ext_match` pulses are sampled as synchronous one-edge strobes.

The stimulus meets these assumptions by changing every input at the falling edge and holding each write for exactly one rising edge. It keeps PERIOD small enough that matches, refills and flag clears interleave within the run time. In the five-phase run, the stimulus waits for `irq` before each refill. This keeps the refill and the clear inside one period, so no match is missed.

// File: rtl/cmp_pulse_pkg.sv
package cmp_pulse_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL   = 3'd0,
        ADDR_PERIOD = 3'd1,
        ADDR_NEXT   = 3'd2,
        ADDR_OUTEN  = 3'd3,
        ADDR_TRIG   = 3'd4,
        ADDR_STATUS = 3'd5,
        ADDR_LATCH  = 3'd6,
        ADDR_COUNT  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_IE_BIT  = 1;

endpackage

// File: rtl/cmp_pulse_timer.sv
module cmp_pulse_timer
    import cmp_pulse_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (run)  state_d = TMR_RUN;
            TMR_RUN:  if (!run) state_d = TMR_IDLE;
            default:            state_d = TMR_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        match = (state_q == TMR_RUN) && (cnt_q == period);
        count = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_q == TMR_RUN && run) begin
            cnt_q <= match ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // R2: a match returns the counter to zero on the next cycle
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (count == '0));

    // R2: while running and not matching, the counter steps by one
    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && run && !match) |=> (count == $past(count) + 1'b1));

    // R9: an idle timer holds zero and produces no match
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_IDLE) |-> (count == '0 && !match));

endmodule

// File: rtl/cmp_pulse_regs.sv
module cmp_pulse_regs
    import cmp_pulse_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 8,
    parameter int TSEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              int_match,
    input  logic [PORT_W-1:0] latch_q,
    input  logic [CNT_W-1:0]  count,
    output logic              run,
    output logic [CNT_W-1:0]  period,
    output logic [PORT_W-1:0] staging,
    output logic [PORT_W-1:0] outen,
    output logic [TSEL_W-1:0] trig_sel,
    output logic              irq
);

    reg_addr_e         addr_e;
    logic              run_q, ie_q, flag_q;
    logic [CNT_W-1:0]  period_q;
    logic [PORT_W-1:0] staging_q, outen_q;
    logic [TSEL_W-1:0] trig_q;
    logic              clr_hit;

    assign addr_e  = reg_addr_e'(bus_addr);
    assign clr_hit = bus_wr && (addr_e == ADDR_STATUS) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            ie_q      <= 1'b0;
            period_q  <= '0;
            staging_q <= '0;
            outen_q   <= '0;
            trig_q    <= '0;
        end else if (bus_wr) begin
            unique case (addr_e)
                ADDR_CTRL: begin
                    run_q <= bus_wdata[CTRL_RUN_BIT];
                    ie_q  <= bus_wdata[CTRL_IE_BIT];
                end
                ADDR_PERIOD: period_q  <= bus_wdata[CNT_W-1:0];
                ADDR_NEXT:   staging_q <= bus_wdata[PORT_W-1:0];
                ADDR_OUTEN:  outen_q   <= bus_wdata[PORT_W-1:0];
                ADDR_TRIG:   trig_q    <= bus_wdata[TSEL_W-1:0];
                ADDR_STATUS, ADDR_LATCH, ADDR_COUNT: ;
                default: ;
            endcase
        end
    end

    // event flag: a new match takes priority over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (int_match) flag_q <= 1'b1;
        else if (clr_hit)   flag_q <= 1'b0;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (addr_e)
            ADDR_CTRL: begin
                bus_rdata[CTRL_RUN_BIT] = run_q;
                bus_rdata[CTRL_IE_BIT]  = ie_q;
            end
            ADDR_PERIOD: bus_rdata[CNT_W-1:0]  = period_q;
            ADDR_NEXT:   bus_rdata[PORT_W-1:0] = staging_q;
            ADDR_OUTEN:  bus_rdata[PORT_W-1:0] = outen_q;
            ADDR_TRIG:   bus_rdata[TSEL_W-1:0] = trig_q;
            ADDR_STATUS: bus_rdata[0]          = flag_q;
            ADDR_LATCH:  bus_rdata[PORT_W-1:0] = latch_q;
            ADDR_COUNT:  bus_rdata[CNT_W-1:0]  = count;
            default:     bus_rdata             = '0;
        endcase
    end

    assign run      = run_q;
    assign period   = period_q;
    assign staging  = staging_q;
    assign outen    = outen_q;
    assign trig_sel = trig_q;
    assign irq      = flag_q & ie_q;

    // R5: every internal match leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        int_match |=> flag_q);

    // R6: a clear with no competing match drops the flag
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !int_match) |=> !flag_q);

    // R6: without a clear the flag is sticky
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_hit) |=> flag_q);

endmodule

// File: rtl/cmp_pulse_xfer.sv
module cmp_pulse_xfer #(
    parameter int PORT_W = 8,
    parameter int GRP_W  = 4,
    parameter int N_EXT  = 3,
    parameter int SEL_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              int_match,
    input  logic [N_EXT-1:0]                  ext_match,
    input  logic [(PORT_W/GRP_W)*SEL_W-1:0]   trig_sel,
    input  logic [PORT_W-1:0]                 staging,
    output logic [PORT_W-1:0]                 latch_q
);

    localparam int N_GRP = PORT_W / GRP_W;
    localparam int N_PAD = 1 << SEL_W;

    logic [N_PAD-1:0] src;
    logic [N_GRP-1:0] fire;

    always_comb begin
        src            = '0;
        src[N_EXT:0]   = {ext_match, int_match};
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [SEL_W-1:0] sel;
        assign sel     = trig_sel[g*SEL_W +: SEL_W];
        assign fire[g] = src[sel];

        // R3: a fired group copies its staging bits
        a_r3_group_copy: assert property (@(posedge clk) disable iff (!rst_n)
            fire[g] |=> (latch_q[g*GRP_W +: GRP_W] == $past(staging[g*GRP_W +: GRP_W])));

        // R7: a group whose source is quiet keeps its bits
        a_r7_group_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !fire[g] |=> (latch_q[g*GRP_W +: GRP_W] == $past(latch_q[g*GRP_W +: GRP_W])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            for (int g = 0; g < N_GRP; g++) begin
                if (fire[g]) latch_q[g*GRP_W +: GRP_W] <= staging[g*GRP_W +: GRP_W];
            end
        end
    end

endmodule

// File: rtl/cmp_pulse_port.sv
module cmp_pulse_port #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 8,
    parameter int GRP_W  = 4,
    parameter int N_EXT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_EXT-1:0]  ext_match,
    output logic              irq,
    output logic [PORT_W-1:0] pulse_out
);

    localparam int N_GRP  = PORT_W / GRP_W;
    localparam int SEL_W  = $clog2(N_EXT + 1);
    localparam int TSEL_W = N_GRP * SEL_W;

    logic              run, int_match;
    logic [CNT_W-1:0]  period, count;
    logic [PORT_W-1:0] staging, outen, latch_q;
    logic [TSEL_W-1:0] trig_sel;

    cmp_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (period),
        .count  (count),
        .match  (int_match)
    );

    cmp_pulse_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .PORT_W (PORT_W),
        .TSEL_W (TSEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_match (int_match),
        .latch_q   (latch_q),
        .count     (count),
        .run       (run),
        .period    (period),
        .staging   (staging),
        .outen     (outen),
        .trig_sel  (trig_sel),
        .irq       (irq)
    );

    cmp_pulse_xfer #(
        .PORT_W (PORT_W),
        .GRP_W  (GRP_W),
        .N_EXT  (N_EXT),
        .SEL_W  (SEL_W)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_match (int_match),
        .ext_match (ext_match),
        .trig_sel  (trig_sel),
        .staging   (staging),
        .latch_q   (latch_q)
    );

    assign pulse_out = latch_q & outen;

endmodule

// File: tb/cmp_pulse_port_bench.sv
`timescale 1ns/1ps
module cmp_pulse_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  ext_match = '0;
    logic        irq;
    logic [7:0]  pulse_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    bit         mon_on = 1'b0;
    logic [7:0] mon_prev = '0;

    always #5 clk = ~clk;

    cmp_pulse_port u_cmp_pulse_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_match (ext_match),
        .irq       (irq),
        .pulse_out (pulse_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; consumes exactly one rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic strobe(input int idx);
        ext_match[idx] = 1'b1;
        @(negedge clk);
        ext_match = '0;
    endtask

    // scoreboard monitor: every port change must match the queue front
    always @(negedge clk) begin
        if (mon_on && pulse_out != mon_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected step", pulse_out, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(pulse_out == e, "R10 phase value", pulse_out, e);
                check($countones(pulse_out) inside {1, 2}, "R10 one or two phases",
                      $countones(pulse_out), 1);
            end
            mon_prev = pulse_out;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0] phases [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20,
                                    8'h30, 8'h10, 8'h18, 8'h08, 8'h88};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pulse_out == 8'h00, "R1 port", pulse_out, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        rd(3'd7, d); check(d == 16'h0, "R1 count", d, 0);
        rd(3'd6, d); check(d == 16'h0, "R1 latch", d, 0);
        rd(3'd5, d); check(d == 16'h0, "R1 status", d, 0);
        rd(3'd0, d); check(d == 16'h0, "R1 ctrl", d, 0);

        // R2 R3 R5 R11: period 4, full enable, internal trigger
        wr(3'd3, 16'h00FF);
        wr(3'd4, 16'h0000);
        wr(3'd1, 16'd4);
        wr(3'd2, 16'h005A);
        rd(3'd1, d); check(d == 16'd4, "R11 period readback", d, 4);
        wr(3'd0, 16'h0003);
        repeat (5) @(negedge clk);
        rd(3'd7, d); check(d == 16'd4, "R2 count reaches period", d, 4);
        check(pulse_out == 8'h00, "R3 no transfer before match", pulse_out, 0);
        check(irq == 1'b0, "R5 no irq before match", irq, 0);
        @(negedge clk);
        check(pulse_out == 8'h5A, "R3 transfer on match", pulse_out, 8'h5A);
        check(irq == 1'b1, "R5 irq after match", irq, 1);
        rd(3'd7, d); check(d == 16'd0, "R2 wrap to zero", d, 0);
        repeat (4) @(negedge clk);
        rd(3'd7, d); check(d == 16'd4, "R2 period N+1", d, 4);
        @(negedge clk);
        rd(3'd7, d); check(d == 16'd0, "R2 second wrap", d, 0);

        // R9 stopped timer
        wr(3'd0, 16'h0002);
        repeat (2) @(negedge clk);
        wr(3'd2, 16'h0077);
        repeat (10) @(negedge clk);
        rd(3'd7, d); check(d == 16'd0, "R9 count held", d, 0);
        check(pulse_out == 8'h5A, "R9 no transfer while stopped", pulse_out, 8'h5A);
        wr(3'd5, 16'h0001);
        check(irq == 1'b0, "R6 clear drops irq", irq, 0);
        rd(3'd5, d); check(d == 16'h0, "R6 status cleared", d, 0);

        // R2 N=0, R5 enable gating, R6 set wins, R8 same-edge write
        wr(3'd1, 16'd0);
        wr(3'd2, 16'h00AA);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        check(pulse_out == 8'h5A, "R2 one cycle to enter run", pulse_out, 8'h5A);
        @(negedge clk);
        check(pulse_out == 8'hAA, "R2 period zero transfer", pulse_out, 8'hAA);
        check(irq == 1'b0, "R5 irq gated by enable", irq, 0);
        rd(3'd5, d); check(d == 16'h1, "R5 flag set", d, 1);
        wr(3'd5, 16'h0001);
        rd(3'd5, d); check(d == 16'h1, "R6 match beats clear", d, 1);
        wr(3'd2, 16'h0011);
        check(pulse_out == 8'hAA, "R8 pre-write value taken", pulse_out, 8'hAA);
        wr(3'd2, 16'h0022);
        check(pulse_out == 8'h11, "R8 lag by one match", pulse_out, 8'h11);
        @(negedge clk);
        check(pulse_out == 8'h22, "R8 new value next match", pulse_out, 8'h22);

        // R4 mask
        wr(3'd3, 16'h000F);
        check(pulse_out == 8'h02, "R4 masked port", pulse_out, 8'h02);
        rd(3'd6, d); check(d == 16'h22, "R4 latch unmasked", d, 8'h22);

        // R7 group trigger select
        wr(3'd0, 16'h0000);
        repeat (2) @(negedge clk);
        wr(3'd3, 16'h00FF);
        wr(3'd4, 16'h0006);   // group0 -> ext_match[1], group1 -> ext_match[0]
        wr(3'd2, 16'h00C3);
        repeat (3) @(negedge clk);
        check(pulse_out == 8'h22, "R7 no strobe no change", pulse_out, 8'h22);
        strobe(0);
        check(pulse_out == 8'hC2, "R7 upper group only", pulse_out, 8'hC2);
        strobe(2);
        check(pulse_out == 8'hC2, "R7 unselected source ignored", pulse_out, 8'hC2);
        strobe(1);
        check(pulse_out == 8'hC3, "R7 lower group", pulse_out, 8'hC3);

        // R10 five-phase sequence through the scoreboard
        wr(3'd4, 16'h0000);
        wr(3'd3, 16'h00F8);
        wr(3'd1, 16'd3);
        wr(3'd5, 16'h0001);
        wr(3'd2, 16'h0080);
        exp_q.push_back(8'h80);
        mon_prev = pulse_out;
        mon_on = 1'b1;
        wr(3'd0, 16'h0003);
        for (int i = 1; i <= 12; i++) begin
            while (!irq) @(negedge clk);
            wr(3'd2, {8'h00, phases[i % 10]});
            exp_q.push_back(phases[i % 10] & 8'hF8);
            wr(3'd5, 16'h0001);
        end
        for (int w = 0; w < 20 && exp_q.size() != 0; w++) @(negedge clk);
        check(exp_q.size() == 0, "R10 all phases seen", exp_q.size(), 0);
        mon_on = 1'b0;
        wr(3'd0, 16'h0000);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule